// File: doc/BRIEF.md
# Outstanding Miss and Atomic Tracker

This block keeps a small, fully associative table of transactions that a level-two line controller has sent toward memory and not yet seen completed. Each slot is keyed by a line address and holds a transient state (read pending, atomics pending, writeback pending), a bit mask of requesters waiting for the line, a dirty flag and a counter of atomics still in flight.

The controller presents one command per cycle. The table answers in the same cycle. It reports whether the address matches a live slot, whether the table is full, and whether the command must be refused so the caller can retry it later. It also reports whether a request must be sent to memory, which requesters a fill reply fans out to, and whether a completion message (with its dirty flag) is due. Read misses to a line that is already pending merge into the existing slot. Atomics are counted, and the slot posts an internal trigger when the count drains; the caller feeds that trigger back to retire the slot.

Top module: `mat_table`

## Requirements
- R1: After reset no slot is live: hit, full, trig_valid and every command output are 0.
- R2: A read (cmd_op 1) whose address matches no slot takes the lowest-numbered free slot as read-pending. The requester set is just cmd_req, the counter is 0, the dirty flag is clear, and mem_req is 1. From the next cycle on, hit is 1 for that address.
- R3: A read that hits a read-pending slot adds cmd_req to its set. mem_req is 1 only when the set then holds exactly one requester, so a second requester merges with no memory request.
- R4: A fill (cmd_op 3) that hits a read-pending slot raises fill_valid with req_mask equal to the full waiting set. It also raises done_valid with done_dirty equal to the slot's dirty flag, and frees the slot, so the same address misses from the next cycle.
- R5: An atomic (cmd_op 2) allocates an atomics-pending slot on a miss, or joins one on a hit. It adds cmd_req to the set, raises the counter by one and raises mem_req.
- R6: An atomic reply (cmd_op 4) that hits an atomics-pending slot with a nonzero counter lowers the counter by one and raises done_valid. When the counter reaches 0, the slot's trigger becomes pending. A reply to any other slot, or to a counter already at 0, does nothing.
- R7: A trigger command (cmd_op 5) that hits a slot with a pending trigger clears the pending trigger. It raises trig_done and frees the slot only if the counter is 0 at that moment; otherwise the slot stays live.
- R8: full is 1 when every slot is live. A read, atomic or writeback (cmd_op 6) that misses while full raises stall and changes nothing.
- R9: stall is raised, with no state change, for a read that hits an atomics-pending or writeback-pending slot, an atomic that hits a read-pending or writeback-pending slot, and a writeback that hits any slot.
- R10: A writeback that misses, with a slot free, allocates a writeback-pending slot with the dirty flag set and raises mem_req. A writeback ack (cmd_op 7) always raises done_valid, with done_dirty equal to the matching slot's dirty flag or 0 on a miss. It frees the slot only if that slot is writeback-pending.
- R11: trig_valid is 1 while any slot has a pending trigger, and trig_addr is the address of the lowest-numbered such slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 idle, 1 read, 2 atomic, 3 fill, 4 atomic reply, 5 trigger, 6 writeback, 7 writeback ack) |
| cmd_addr | input | ADDR_W | Line address of the command |
| cmd_req | input | RID_W | Requester index |
| hit | output | 1 | cmd_addr matches a live slot |
| full | output | 1 | Every slot is live |
| stall | output | 1 | Command refused, caller retries |
| mem_req | output | 1 | Command must be forwarded to memory |
| fill_valid | output | 1 | Fill reply to be fanned out |
| req_mask | output | REQ_N | Waiting requesters of the matching slot |
| done_valid | output | 1 | Completion message due |
| done_dirty | output | 1 | Dirty flag carried by the completion |
| trig_valid | output | 1 | A trigger is pending |
| trig_addr | output | ADDR_W | Address of the pending trigger |
| trig_done | output | 1 | Trigger command classified as done |

## Verification
The bench targets the merge rule: a second requester on a pending read must not raise mem_req, while a lone requester re-reading must. A design that counted requests instead of the set would get one of these wrong. It drives the atomic race, where a new atomic arrives between the drain and the trigger. A design that classified at drain time would free a live slot there, and the next reply would be lost. It fills the table and issues misses so that allocation into a live slot shows up as a hit on the wrong address. It also checks that a freed slot misses on the next cycle.

// File: rtl/mat_pkg.sv
`timescale 1ns/1ps
package mat_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_ATOM  = 3'd2,
    OP_FILL  = 3'd3,
    OP_AREPL = 3'd4,
    OP_TRIG  = 3'd5,
    OP_WRBK  = 3'd6,
    OP_WBACK = 3'd7
  } mat_op_e;

  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_RD   = 2'd1,
    SL_ATOM = 2'd2,
    SL_WB   = 2'd3
  } mat_slot_e;
endpackage

// File: rtl/mat_pick.sv
`timescale 1ns/1ps
module mat_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] gnt;

  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        idx = IW'(i);
      end
    end
  end

  assign any = |req;

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && ((req & (gnt - 1'b1)) == '0))); // R11
endmodule

// File: rtl/mat_cam.sv
`timescale 1ns/1ps
module mat_cam #(
  parameter int N  = 4,
  parameter int AW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         live,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]        key,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = live[g] && (tags[g] == key);
  end

  mat_pick #(.N(N)) u_enc (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (match),
    .any  (hit),
    .idx  (hit_idx)
  );

  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1); // R2
endmodule

// File: rtl/mat_table.sv
`timescale 1ns/1ps
module mat_table
  import mat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int ADDR_W  = 16,
  parameter int REQ_N   = 4,
  parameter int CNT_W   = 4,
  localparam int IW     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int RID_W  = (REQ_N > 1) ? $clog2(REQ_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [RID_W-1:0]  cmd_req,
  output logic              hit,
  output logic              full,
  output logic              stall,
  output logic              mem_req,
  output logic              fill_valid,
  output logic [REQ_N-1:0]  req_mask,
  output logic              done_valid,
  output logic              done_dirty,
  output logic              trig_valid,
  output logic [ADDR_W-1:0] trig_addr,
  output logic              trig_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  mat_slot_e                     st_q    [NUM_ENT];
  logic [NUM_ENT-1:0][ADDR_W-1:0] addr_q;
  logic [REQ_N-1:0]              mask_q  [NUM_ENT];
  logic [CNT_W-1:0]              cnt_q   [NUM_ENT];
  logic [NUM_ENT-1:0]            dirty_q;
  logic [NUM_ENT-1:0]            pend_q;
  logic [NUM_ENT-1:0]            live;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_live
    assign live[g] = (st_q[g] != SL_FREE);
  end

  logic          free_any, pend_any;
  logic [IW-1:0] hit_idx, free_idx, pend_idx, sel;

  mat_cam #(.N(NUM_ENT), .AW(ADDR_W)) u_cam (
    .clk    (clk),
    .rst_n  (rst_s),
    .live   (live),
    .tags   (addr_q),
    .key    (cmd_addr),
    .hit    (hit),
    .hit_idx(hit_idx)
  );

  mat_pick #(.N(NUM_ENT)) u_free (
    .clk  (clk),
    .rst_n(rst_s),
    .req  (~live),
    .any  (free_any),
    .idx  (free_idx)
  );

  mat_pick #(.N(NUM_ENT)) u_trig (
    .clk  (clk),
    .rst_n(rst_s),
    .req  (pend_q),
    .any  (pend_any),
    .idx  (pend_idx)
  );

  assign full       = ~free_any;
  assign trig_valid = pend_any;
  assign trig_addr  = addr_q[pend_idx];
  assign sel        = hit ? hit_idx : free_idx;

  mat_slot_e        cur_st;
  logic [REQ_N-1:0] cur_mask, req_bit;
  logic [CNT_W-1:0] cur_cnt;
  logic             cur_dirty, cur_pend;

  always_comb begin
    cur_st    = hit ? st_q[hit_idx]    : SL_FREE;
    cur_mask  = hit ? mask_q[hit_idx]  : '0;
    cur_cnt   = hit ? cnt_q[hit_idx]   : '0;
    cur_dirty = hit ? dirty_q[hit_idx] : 1'b0;
    cur_pend  = hit ? pend_q[hit_idx]  : 1'b0;
    req_bit   = '0;
    req_bit[cmd_req] = 1'b1;
  end

  assign req_mask = cur_mask;

  // next-state for the one slot a command may touch
  mat_op_e          op;
  logic             wr_en;
  mat_slot_e        n_st;
  logic [REQ_N-1:0] n_mask;
  logic [CNT_W-1:0] n_cnt;
  logic             n_dirty, n_pend;

  assign op = mat_op_e'(cmd_op);

  always_comb begin
    wr_en      = 1'b0;
    n_st       = cur_st;
    n_mask     = cur_mask;
    n_cnt      = cur_cnt;
    n_dirty    = cur_dirty;
    n_pend     = cur_pend;
    stall      = 1'b0;
    mem_req    = 1'b0;
    fill_valid = 1'b0;
    done_valid = 1'b0;
    done_dirty = 1'b0;
    trig_done  = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_READ: begin
          if (hit && cur_st == SL_RD) begin
            wr_en   = 1'b1;
            n_mask  = cur_mask | req_bit;
            mem_req = ($countones(n_mask) == 1);
          end else if (hit || full) begin
            stall = 1'b1;
          end else begin
            wr_en   = 1'b1;
            n_st    = SL_RD;
            n_mask  = req_bit;
            n_cnt   = '0;
            n_dirty = 1'b0;
            n_pend  = 1'b0;
            mem_req = 1'b1;
          end
        end
        OP_ATOM: begin
          if ((hit && cur_st != SL_ATOM) || (!hit && full)) begin
            stall = 1'b1;
          end else begin
            wr_en   = 1'b1;
            n_st    = SL_ATOM;
            n_mask  = (hit ? cur_mask : '0) | req_bit;
            n_cnt   = (hit ? cur_cnt : '0) + 1'b1;
            n_dirty = hit ? cur_dirty : 1'b0;
            n_pend  = hit ? cur_pend : 1'b0;
            mem_req = 1'b1;
          end
        end
        OP_FILL: begin
          if (hit && cur_st == SL_RD) begin
            fill_valid = 1'b1;
            done_valid = 1'b1;
            done_dirty = cur_dirty;
            wr_en      = 1'b1;
            n_st       = SL_FREE;
            n_mask     = '0;
          end
        end
        OP_AREPL: begin
          if (hit && cur_st == SL_ATOM && cur_cnt != '0) begin
            done_valid = 1'b1;
            done_dirty = cur_dirty;
            wr_en      = 1'b1;
            n_cnt      = cur_cnt - 1'b1;
            if (cur_cnt == CNT_W'(1)) n_pend = 1'b1;
          end
        end
        OP_TRIG: begin
          if (hit && cur_pend) begin
            wr_en  = 1'b1;
            n_pend = 1'b0;
            if (cur_cnt == '0) begin
              trig_done = 1'b1;
              n_st      = SL_FREE;
              n_mask    = '0;
            end
          end
        end
        OP_WRBK: begin
          if (hit || full) begin
            stall = 1'b1;
          end else begin
            wr_en   = 1'b1;
            n_st    = SL_WB;
            n_mask  = '0;
            n_cnt   = '0;
            n_dirty = 1'b1;
            n_pend  = 1'b0;
            mem_req = 1'b1;
          end
        end
        OP_WBACK: begin
          done_valid = 1'b1;
          done_dirty = cur_dirty;
          if (hit && cur_st == SL_WB) begin
            wr_en  = 1'b1;
            n_st   = SL_FREE;
            n_mask = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        st_q[i]    <= SL_FREE;
        addr_q[i]  <= '0;
        mask_q[i]  <= '0;
        cnt_q[i]   <= '0;
        dirty_q[i] <= 1'b0;
        pend_q[i]  <= 1'b0;
      end
    end else if (wr_en) begin
      st_q[sel]    <= n_st;
      addr_q[sel]  <= cmd_addr;
      mask_q[sel]  <= n_mask;
      cnt_q[sel]   <= n_cnt;
      dirty_q[sel] <= n_dirty;
      pend_q[sel]  <= n_pend;
    end
  end

  AST_READ_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && op == OP_READ && !hit && !stall)
      |=> $countones(live) == $past($countones(live)) + 1); // R2
  AST_MEMREQ_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_s)
    mem_req |-> !stall); // R3
  AST_FILL_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_s)
    fill_valid |=> $countones(live) + 1 == $past($countones(live))); // R4
  AST_NO_CNT_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && op == OP_ATOM && !stall) |-> cur_cnt != CNT_MAX); // R5
  AST_DRAIN_TRIGGERS: assert property (@(posedge clk) disable iff (!rst_s)
    (done_valid && op == OP_AREPL && cur_cnt == CNT_W'(1)) |=> trig_valid); // R6
  AST_FULL_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && full && !hit && (op == OP_READ || op == OP_ATOM || op == OP_WRBK))
      |-> stall); // R8
  AST_STALL_HOLDS_LIVE: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && stall) |=> $stable(live)); // R9
endmodule

// File: tb/mat_table_tb.sv
`timescale 1ns/1ps
module mat_table_tb;
  localparam int NE = 4;
  localparam int AW = 16;
  localparam int RN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [1:0]    cmd_req = '0;
  logic          hit, full, stall, mem_req, fill_valid, done_valid, done_dirty;
  logic          trig_valid, trig_done;
  logic [RN-1:0] req_mask;
  logic [AW-1:0] trig_addr;

  always #2.5 clk = ~clk;

  mat_table #(.NUM_ENT(NE), .ADDR_W(AW), .REQ_N(RN), .CNT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_req(cmd_req), .hit(hit), .full(full),
    .stall(stall), .mem_req(mem_req), .fill_valid(fill_valid),
    .req_mask(req_mask), .done_valid(done_valid), .done_dirty(done_dirty),
    .trig_valid(trig_valid), .trig_addr(trig_addr), .trig_done(trig_done)
  );

  int n_chk = 0;
  int n_fail = 0;

  // model: 0 free, 1 read, 2 atomic, 3 writeback
  int            m_st   [NE];
  logic [AW-1:0] m_addr [NE];
  logic [RN-1:0] m_mask [NE];
  int            m_cnt  [NE];
  bit            m_dirty[NE];
  bit            m_pend [NE];

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int find_hit(input logic [AW-1:0] a);
    for (int i = 0; i < NE; i++) if (m_st[i] != 0 && m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic int find_free();
    for (int i = 0; i < NE; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int find_pend();
    for (int i = 0; i < NE; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  function automatic int first_pend_addr_ok();
    return find_pend();
  endfunction

  task automatic step(input int op, input logic [AW-1:0] a, input int r, input string tag);
    int h, fr, tp, s;
    bit e_stall, e_mreq, e_fill, e_done, e_dd, e_td;
    logic [RN-1:0] e_mask, rb;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = a; cmd_req = 2'(r);
    #1;
    h = find_hit(a); fr = find_free(); tp = find_pend();
    e_stall = 0; e_mreq = 0; e_fill = 0; e_done = 0; e_dd = 0; e_td = 0;
    e_mask = (h >= 0) ? m_mask[h] : '0;
    rb = '0; rb[r] = 1'b1;
    s = (h >= 0) ? m_st[h] : 0;
    chk("R11", "trig_valid", 32'(trig_valid), 32'(tp >= 0));
    if (tp >= 0) chk("R11", "trig_addr", 32'(trig_addr), 32'(m_addr[tp]));
    chk("R2", "hit", 32'(hit), 32'(h >= 0));
    chk("R8", "full", 32'(full), 32'(fr < 0));
    chk("R4", "req_mask", 32'(req_mask), 32'(e_mask));
    case (op)
      1: if (h >= 0 && s == 1) begin
           m_mask[h] |= rb; e_mreq = ($countones(m_mask[h]) == 1);
         end else if (h >= 0 || fr < 0) e_stall = 1;
         else begin
           m_st[fr] = 1; m_addr[fr] = a; m_mask[fr] = rb; m_cnt[fr] = 0;
           m_dirty[fr] = 0; m_pend[fr] = 0; e_mreq = 1;
         end
      2: if ((h >= 0 && s != 2) || (h < 0 && fr < 0)) e_stall = 1;
         else if (h >= 0) begin
           m_mask[h] |= rb; m_cnt[h]++; e_mreq = 1;
         end else begin
           m_st[fr] = 2; m_addr[fr] = a; m_mask[fr] = rb; m_cnt[fr] = 1;
           m_dirty[fr] = 0; m_pend[fr] = 0; e_mreq = 1;
         end
      3: if (h >= 0 && s == 1) begin
           e_fill = 1; e_done = 1; e_dd = m_dirty[h]; m_st[h] = 0; m_mask[h] = '0;
         end
      4: if (h >= 0 && s == 2 && m_cnt[h] != 0) begin
           e_done = 1; e_dd = m_dirty[h]; m_cnt[h]--;
           if (m_cnt[h] == 0) m_pend[h] = 1;
         end
      5: if (h >= 0 && m_pend[h]) begin
           m_pend[h] = 0;
           if (m_cnt[h] == 0) begin e_td = 1; m_st[h] = 0; m_mask[h] = '0; end
         end
      6: if (h >= 0 || fr < 0) e_stall = 1;
         else begin
           m_st[fr] = 3; m_addr[fr] = a; m_mask[fr] = '0; m_cnt[fr] = 0;
           m_dirty[fr] = 1; m_pend[fr] = 0; e_mreq = 1;
         end
      7: begin
           e_done = 1; e_dd = (h >= 0) ? m_dirty[h] : 0;
           if (h >= 0 && s == 3) begin m_st[h] = 0; m_mask[h] = '0; end
         end
      default: ;
    endcase
    chk(tag, "stall R9", 32'(stall), 32'(e_stall));
    chk(tag, "mem_req R3", 32'(mem_req), 32'(e_mreq));
    chk(tag, "fill_valid R4", 32'(fill_valid), 32'(e_fill));
    chk(tag, "done_valid R10", 32'(done_valid), 32'(e_done));
    chk(tag, "done_dirty R10", 32'(done_dirty), 32'(e_dd));
    chk(tag, "trig_done R7", 32'(trig_done), 32'(e_td));
    @(posedge clk);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired before the end of the run");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int op, ai, tp, h;
    logic [AW-1:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < NE; i++) begin
      m_st[i] = 0; m_addr[i] = '0; m_mask[i] = '0; m_cnt[i] = 0; m_dirty[i] = 0; m_pend[i] = 0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "hit", 32'(hit), 32'd0);
    chk("R1", "full", 32'(full), 32'd0);
    chk("R1", "trig_valid", 32'(trig_valid), 32'd0);
    chk("R1", "mem_req", 32'(mem_req), 32'd0);
    // R2 R3 R4: merge two readers, fill fans out, slot freed
    step(1, 16'h0100, 0, "R2");
    step(1, 16'h0100, 1, "R3");
    step(1, 16'h0100, 1, "R3");
    step(3, 16'h0100, 0, "R4");
    step(1, 16'h0100, 2, "R4");
    step(3, 16'h0100, 0, "R4");
    // R5 R6 R7: atomic drain, late atomic before trigger, then done
    step(2, 16'h0200, 2, "R5");
    step(2, 16'h0200, 3, "R5");
    step(4, 16'h0200, 0, "R6");
    step(4, 16'h0200, 0, "R6");
    step(4, 16'h0200, 0, "R6");
    step(2, 16'h0200, 1, "R7");
    step(5, 16'h0200, 0, "R7");
    step(4, 16'h0200, 0, "R7");
    step(5, 16'h0200, 0, "R7");
    step(1, 16'h0200, 0, "R7");
    // R9 R10: conflicts and writeback
    step(6, 16'h0300, 0, "R10");
    step(1, 16'h0300, 0, "R9");
    step(2, 16'h0300, 0, "R9");
    step(6, 16'h0200, 0, "R9");
    step(7, 16'h0999, 0, "R10");
    step(7, 16'h0300, 0, "R10");
    // R8: fill the table and miss
    step(6, 16'h0400, 0, "R8");
    step(2, 16'h0500, 1, "R8");
    step(6, 16'h0600, 0, "R8");
    step(1, 16'h0700, 0, "R8");
    step(2, 16'h0701, 0, "R8");
    step(7, 16'h0400, 0, "R8");
    step(1, 16'h0700, 3, "R8");
    // random mix over a small address pool
    for (int k = 0; k < 4000; k++) begin
      op = $urandom_range(1, 7);
      ai = $urandom_range(0, 5);
      a = 16'h1000 + 16'(ai);
      h = find_hit(a);
      if (op == 2 && h >= 0 && m_cnt[h] >= 12) op = 4;
      if (op == 5) begin
        tp = find_pend();
        if (tp >= 0 && $urandom_range(0, 3) != 0) a = m_addr[tp];
      end
      step(op, a, $urandom_range(0, 3), "R11");
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule